// File: doc/BRIEF.md
# Entropy Conditioning CRC Register

This block turns three single-bit noise streams into a 64-bit random word. On every clock it XORs the streams whose enable bits are set into one bit. That bit is shifted into a 64-bit CRC accumulator with a fixed feedback polynomial. The accumulator state is the random data word. A consumer reads it over a ready/valid request port.

A control register sets several things: which sources take part, whether the read interlock is active, the minimum number of cycles between accepted reads, and whether the data output is driven. It also holds an oscillator-tuning field, which is only stored and read back. With the interlock active, a read request is held off until enough accumulation cycles have passed since the previous accepted read. The noise sources themselves are outside the block.

Top module: `entropy_crc_top`

## Requirements
- R1: After reset the data output is 0. The interlock is not ready. The control readback is 24'h00080F: all three sources enabled, interlock on, wait count 8, output enabled, tuning field 0.
- R2: Each cycle the mixed bit is the XOR of `raw_i[k]` over every k whose enable bit `ctl[k]` (bits 2:0) is 1. A disabled source has no effect on the data.
- R3: Each cycle the state shifts left by one. The feedback is the old bit 63 XOR the mixed bit. When the feedback is 1, the state is XORed with 64'h231DCEE91262B8A3, which is the low 64 terms of the polynomial with x^64. From state 0, one mixed 1 gives 64'h231DCEE91262B8A3, and a following 0 gives 64'h463B9DD224C57146.
- R4: With every source disabled, the state keeps stepping with a mixed bit of 0.
- R5: While the output-select field (bits 5:4) is not 2'b10, `rd_data_o` equals the current accumulator state, so an accepted read returns the state in its accept cycle.
- R6: Output-select 2'b10 forces `rd_data_o` to 0 while accumulation continues. Returning the field to 2'b00 shows the state that built up in the meantime.
- R7: With the interlock bit (bit 3) set and wait count W (bits 23:8) greater than 0, `rd_ready_o` is low for exactly W cycles after an accepted read (`rd_valid_i && rd_ready_o` at a clock edge) and after reset. It then goes high.
- R8: The interlock counter saturates. An idle time longer than W leaves `rd_ready_o` high, and the next accepted read restarts the count.
- R9: With the interlock bit clear, `rd_ready_o` stays high for any wait count, including for back-to-back reads.
- R10: With the interlock bit set and W = 0, back-to-back reads are never stalled.
- R11: A control write (`ctl_we_i`) takes effect at the next clock edge and is returned unchanged on `ctl_rdata_o`. The tuning field (bits 7:6) has no effect on the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 24 | Control register write value |
| ctl_rdata_o | output | 24 | Control register readback |
| raw_i | input | 3 | Raw noise bits, one per source |
| rd_valid_i | input | 1 | Read request |
| rd_ready_o | output | 1 | Interlock open, request accepted this cycle |
| rd_data_o | output | 64 | Random data word |

## Verification
The hardest case to reach is the interlock edge: a read must land exactly W cycles after the previous accept, and the counter must saturate during a long idle time. The bench counts cycles from each accept until ready rises and compares the count with W. It then leaves the port idle for well beyond W before issuing the next read. The data path is compared every cycle against a reference accumulator, driven by a pseudo-random noise pattern and a sweep over all eight enable masks. A hand-derived two-step answer from state 0 pins down the polynomial.

// File: rtl/entropy_crc_pkg.sv
package entropy_crc_pkg;
  localparam int N_SRC   = 3;
  localparam int CRC_W   = 64;
  localparam int WAIT_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;
  localparam logic [1:0] OSEL_NOOUT = 2'b10;

  typedef struct packed {
    logic [WAIT_W-1:0] wait_cnt;
    logic [1:0]        vco_sel;
    logic [1:0]        out_sel;
    logic              lock_en;
    logic [N_SRC-1:0]  src_en;
  } ctl_t;

  localparam int CTL_BITS = $bits(ctl_t);
endpackage

// File: rtl/entropy_mixer.sv
module entropy_mixer #(
  parameter int N = 3
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] en_i,
  output logic         bit_o
);
  logic [N-1:0] gated;

  for (genvar k = 0; k < N; k++) begin : g_src
    assign gated[k] = raw_i[k] & en_i[k];
  end

  assign bit_o = ^gated;
endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int             W    = 64,
  parameter logic [W-1:0]   POLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = state_q[W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= {state_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign state_o = state_q;

  AST_CRC_ZERO_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i == state_q[W-1]) |=> !state_q[0]) else $error("zero feedback set lsb"); // R3
  AST_CRC_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == '0 && !bit_i) |=> (state_q == '0)) else $error("zero state left"); // R4
endmodule

// File: rtl/read_interlock.sv
module read_interlock #(
  parameter int WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_en_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              valid_i,
  output logic              ready_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              acc;

  assign ready_o = !lock_en_i || (cnt_q >= wait_i);
  assign acc     = valid_i && ready_o;

  // restart on accept, saturate at the wait count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (acc)            cnt_q <= '0;
    else if (cnt_q < wait_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_STALL_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && lock_en_i && wait_i != '0) |=> (!ready_o || !$stable(wait_i) || !lock_en_i))
    else $error("read not stalled after accept"); // R7
  AST_READY_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !acc) |=> (ready_o || !$stable(wait_i) || !$stable(lock_en_i)))
    else $error("ready dropped while idle"); // R8
endmodule

// File: rtl/entropy_crc_top.sv
module entropy_crc_top
  import entropy_crc_pkg::*;
#(
  parameter int RST_WAIT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_we_i,
  input  logic [CTL_BITS-1:0] ctl_wdata_i,
  output logic [CTL_BITS-1:0] ctl_rdata_o,
  input  logic [N_SRC-1:0]    raw_i,
  input  logic                rd_valid_i,
  output logic                rd_ready_o,
  output logic [CRC_W-1:0]    rd_data_o
);
  localparam ctl_t CTL_RST = '{
    wait_cnt: WAIT_W'(RST_WAIT),
    vco_sel:  2'b00,
    out_sel:  2'b00,
    lock_en:  1'b1,
    src_en:   {N_SRC{1'b1}}
  };

  ctl_t             ctl_q;
  logic             mix_bit;
  logic [CRC_W-1:0] crc_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= CTL_RST;
    else if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
  end

  assign ctl_rdata_o = ctl_q;

  entropy_mixer #(.N(N_SRC)) u_mixer (
    .raw_i (raw_i),
    .en_i  (ctl_q.src_en),
    .bit_o (mix_bit)
  );

  crc_accum #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (mix_bit),
    .state_o (crc_state)
  );

  read_interlock #(.WAIT_W(WAIT_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_en_i (ctl_q.lock_en),
    .wait_i    (ctl_q.wait_cnt),
    .valid_i   (rd_valid_i),
    .ready_o   (rd_ready_o)
  );

  assign rd_data_o = (ctl_q.out_sel == OSEL_NOOUT) ? '0 : crc_state;

  AST_SRC_OFF_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.src_en == '0 && crc_state == '0) |=> (crc_state == '0 || $past(ctl_we_i)))
    else $error("disabled sources changed state"); // R2
endmodule

// File: tb/entropy_crc_top_bench.sv
`timescale 1ns/1ps
module entropy_crc_top_bench;
  localparam logic [63:0] POLY = 64'h231D_CEE9_1262_B8A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [23:0] ctl_wdata = '0;
  logic [23:0] ctl_rdata;
  logic [2:0]  raw = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit noise_on = 1'b0;
  logic [15:0] nz = 16'hACE1;

  logic [63:0] exp_crc;
  logic [23:0] mdl_ctl;

  always #2.5 clk = ~clk;

  entropy_crc_top u_entropy_crc_top (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .raw_i(raw), .rd_valid_i(rd_valid),
    .rd_ready_o(rd_ready), .rd_data_o(rd_data)
  );

  function automatic logic [63:0] crc_step(logic [63:0] s, logic b);
    logic fb = s[63] ^ b;
    return {s[62:0], 1'b0} ^ (fb ? POLY : 64'h0);
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_crc <= '0;
      mdl_ctl <= 24'h00080F;
    end else begin
      exp_crc <= crc_step(exp_crc, ^(raw & mdl_ctl[2:0]));
      if (ctl_we) mdl_ctl <= ctl_wdata;
    end
  end

  always @(negedge clk) begin
    if (noise_on) begin
      nz  <= {nz[14:0], nz[15] ^ nz[13] ^ nz[12] ^ nz[10]};
      raw <= nz[2:0] ^ nz[9:7];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [23:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic count_to_ready(output int n);
    n = 0;
    while (!rd_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic accept_one;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic t_reset;
    int n;
    chk(rd_data == 64'h0, "R1 data", rd_data, 64'h0);
    chk(!rd_ready, "R1 ready", 64'(rd_ready), 64'h0);
    chk(ctl_rdata == 24'h00080F, "R1 ctl", 64'(ctl_rdata), 64'h00080F);
    count_to_ready(n);
    chk(n == 8, "R7 reset wait", 64'(n), 64'd8);
  endtask

  task automatic t_kat;
    raw = 3'b001;
    @(negedge clk);
    raw = 3'b000;
    chk(rd_data == POLY, "R3 step1", rd_data, POLY);
    @(negedge clk);
    chk(rd_data == 64'h463B9DD224C57146, "R3 step2", rd_data, 64'h463B9DD224C57146);
  endtask

  task automatic t_read_wait8;
    int n;
    noise_on = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_ready, "R8 idle ready", 64'(rd_ready), 64'h1);
    rd_valid = 1'b1;
    chk(rd_data == exp_crc, "R5 read data", rd_data, exp_crc);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(!rd_ready, "R7 stall after read", 64'(rd_ready), 64'h0);
    count_to_ready(n);
    chk(n == 8, "R7 spacing 8", 64'(n), 64'd8);
  endtask

  task automatic t_mix;
    for (int m = 0; m < 8; m++) begin
      bit bad = 1'b0;
      logic [63:0] a = '0, e = '0;
      write_ctl({16'd8, 2'b00, 2'b00, 1'b1, 3'(m)});
      for (int c = 0; c < 24; c++) begin
        @(negedge clk);
        if (rd_data !== exp_crc && !bad) begin bad = 1'b1; a = rd_data; e = exp_crc; end
      end
      if (m == 0) chk(!bad, "R4 all sources off", a, e);
      else        chk(!bad, "R2 enable mask", a, e);
    end
    write_ctl(24'h00080F);
  endtask

  task automatic t_noout;
    bit bad = 1'b0;
    write_ctl({16'd8, 2'b00, 2'b10, 1'b1, 3'b111});
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (rd_data !== 64'h0) bad = 1'b1;
    end
    chk(!bad, "R6 no output", rd_data, 64'h0);
    write_ctl({16'd8, 2'b00, 2'b00, 1'b1, 3'b111});
    chk(rd_data == exp_crc && exp_crc != 64'h0, "R6 accumulated", rd_data, exp_crc);
  endtask

  task automatic t_vco;
    bit bad = 1'b0;
    logic [23:0] v = {16'd8, 2'b11, 2'b01, 1'b1, 3'b111};
    write_ctl(v);
    chk(ctl_rdata == v, "R11 readback", 64'(ctl_rdata), 64'(v));
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (rd_data !== exp_crc) bad = 1'b1;
    end
    chk(!bad, "R11 tuning no effect", rd_data, exp_crc);
  endtask

  task automatic t_wait5_sat;
    int n;
    bit bad = 1'b0;
    write_ctl({16'd5, 2'b00, 2'b00, 1'b1, 3'b111});
    count_to_ready(n);
    accept_one();
    count_to_ready(n);
    chk(n == 5, "R7 spacing 5", 64'(n), 64'd5);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!rd_ready) bad = 1'b1;
    end
    chk(!bad, "R8 saturated ready", 64'(rd_ready), 64'h1);
    accept_one();
    chk(!rd_ready, "R8 restart", 64'(rd_ready), 64'h0);
    count_to_ready(n);
    chk(n == 5, "R8 restart spacing", 64'(n), 64'd5);
  endtask

  task automatic b2b(input string req);
    bit bad = 1'b0;
    logic [63:0] a = '0, e = '0;
    rd_valid = 1'b1;
    for (int c = 0; c < 10; c++) begin
      if ((!rd_ready || rd_data !== exp_crc) && !bad) begin bad = 1'b1; a = rd_data; e = exp_crc; end
      @(negedge clk);
    end
    rd_valid = 1'b0;
    chk(!bad, req, a, e);
  endtask

  task automatic t_nomode;
    write_ctl({16'd50, 2'b00, 2'b00, 1'b0, 3'b111});
    b2b("R9 no stall");
  endtask

  task automatic t_wait0;
    write_ctl({16'd0, 2'b00, 2'b00, 1'b1, 3'b111});
    b2b("R10 wait zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_kat();
    t_read_wait8();
    t_mix();
    t_noout();
    t_vco();
    t_wait5_sat();
    t_nomode();
    t_wait0();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule